// File: doc/BRIEF.md
# Double-Buffered Single-Channel PWM Generator

This block produces one pulse-width-modulated output from an up-counter. The counter runs from zero to an active period value and then wraps. The output is compared against an active compare value and sent through a register. Software programs the block through a write-only register port. While the block is stopped, software loads the period and compare values directly. While it is running, software loads them through a second pair of holding registers. The held pair moves into the active pair only at the next wrap of the counter, so the period in progress always runs to its end with the old settings.

A control word has three bits. One bit runs or freezes the counter. One bit enables the waveform; when this bit is clear, the output is held low. The third bit inverts the output, so that the compare value then sets the low time of each period instead of the high time. Register offsets are byte addresses of 32-bit words. Offset 0x00 is control. Offset 0x04 is the active period and offset 0x08 the active compare. Offset 0x0C is the held period and offset 0x10 the held compare. In the control word, bit 0 is run, bit 1 is waveform enable and bit 2 is invert.

Top module: `shadow_pwm`

## Requirements
- R1: Reset clears the control word, all four value registers and the counter, and drives `pwm_o` low. Setting run and waveform enable with no value written afterwards keeps `pwm_o` low.
- R2: While run is set, the counter steps by one each clock from 0 to the active period P and returns to 0 on the clock after it reaches P, so each period lasts P+1 clocks.
- R3: With invert clear, `pwm_o` is high for the first C clocks of each period (counter below the active compare value C) and low for the rest. C=0 gives a constant low output, and C>P gives a constant high output.
- R4: With invert (bit 2) set, the output of R3 is complemented, so C sets the low time of each period.
- R5: When waveform enable (bit 1) is clear, `pwm_o` is low from the clock after the control write, whatever the counter and invert bit are.
- R6: When run (bit 0) is cleared, the counter holds its value and `pwm_o` stays constant at the level that value gives.
- R7: A write to the held period (0x0C) or held compare (0x10) leaves the period in progress unchanged. Both held values become active at the next counter wrap.
- R8: A transfer at a wrap happens only if a held register was written since the previous wrap. A value written directly to an active register while running therefore stays in force over later wraps.
- R9: A period of 1 with a compare of 1 gives an output that alternates one clock high and one clock low.
- R10: Writes to offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 change no register.
- R11: `pwm_o` is registered. It reflects the counter and compare values of the clock before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the register written |
| wr_data | input | DATA_W | Write data |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The bench sweeps every period from 1 to 6 against compare values from 0 past the period, with both polarities. An off-by-one in the wrap would stretch each period by one clock, and a wrong comparison would add or drop a high clock at the edges of the compare range. A held update is written in the middle of a period. If the transfer happened at once, the old period would be cut short. A direct compare write follows the transfer. If the transfer ran without checking for a pending update, the stale held value would come back at the next wrap. The bench also covers freezing the counter at a high level, turning the waveform off, writes to unmapped offsets, and the minimal 1/1 setting. A decoder that ignored high address bits would alias unmapped offsets onto live registers.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;

  // control word layout: bit 0 run, bit 1 waveform enable, bit 2 invert
  typedef struct packed {
    logic invert;
    logic pwm_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_BITS = 3;

  // byte offsets of the 32-bit registers
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_PER    = 'h04;
  localparam int OFS_CMP    = 'h08;
  localparam int OFS_PER_SH = 'h0C;
  localparam int OFS_CMP_SH = 'h10;

endpackage

// File: rtl/shadow_pwm_regs.sv
module shadow_pwm_regs
  import shadow_pwm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wrap,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  act_per,
  output logic [CNT_W-1:0]  act_cmp
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_PER    = ADDR_W'(OFS_PER);
  localparam logic [ADDR_W-1:0] A_CMP    = ADDR_W'(OFS_CMP);
  localparam logic [ADDR_W-1:0] A_PER_SH = ADDR_W'(OFS_PER_SH);
  localparam logic [ADDR_W-1:0] A_CMP_SH = ADDR_W'(OFS_CMP_SH);

  logic [CNT_W-1:0] sh_per;
  logic [CNT_W-1:0] sh_cmp;
  logic             pending;
  logic             sh_wr;
  logic             act_wr;
  logic [CNT_W-1:0] wr_val;

  assign wr_val = wr_data[CNT_W-1:0];
  assign sh_wr  = wr_en && (wr_addr == A_PER_SH || wr_addr == A_CMP_SH);
  assign act_wr = wr_en && (wr_addr == A_PER || wr_addr == A_CMP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      act_per <= '0;
      act_cmp <= '0;
      sh_per  <= '0;
      sh_cmp  <= '0;
      pending <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CTRL:   ctrl    <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
          A_PER:    act_per <= wr_val;
          A_CMP:    act_cmp <= wr_val;
          A_PER_SH: sh_per  <= wr_val;
          A_CMP_SH: sh_cmp  <= wr_val;
          default:  ;
        endcase
      end
      // a transfer at the boundary wins over a same-cycle direct write
      if (wrap && pending) begin
        act_per <= sh_per;
        act_cmp <= sh_cmp;
      end
      // a held write in the boundary cycle keeps the flag for the next one
      if (sh_wr)
        pending <= 1'b1;
      else if (wrap)
        pending <= 1'b0;
    end
  end

  // R7
  shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && pending) |=> (act_per == $past(sh_per) && act_cmp == $past(sh_cmp)));

  // R8
  no_stale_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && !pending && !act_wr) |=> ($stable(act_per) && $stable(act_cmp)));

endmodule

// File: rtl/shadow_pwm_counter.sv
module shadow_pwm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  // >= keeps the counter bounded if the period is lowered below it
  assign wrap = run && (cnt >= period);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (wrap)
      cnt <= '0;
    else if (run)
      cnt <= cnt + CNT_W'(1);
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt < period) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == $past(cnt)));

endmodule

// File: rtl/shadow_pwm_out.sv
module shadow_pwm_out #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_en,
  input  logic             invert,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             pwm_o
);

  logic active_phase;

  assign active_phase = (cnt < cmp);

  always_ff @(posedge clk) begin
    if (rst)
      pwm_o <= 1'b0;
    else
      pwm_o <= pwm_en && (active_phase ^ invert);
  end

  // R5
  pwm_off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> !pwm_o);

  // R4
  inv_full_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_en && invert && cnt < cmp) |=> !pwm_o);

endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import shadow_pwm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] act_per;
  logic [CNT_W-1:0] act_cmp;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  shadow_pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wrap    (wrap),
    .ctrl    (ctrl),
    .act_per (act_per),
    .act_cmp (act_cmp)
  );

  shadow_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (ctrl.run),
    .period (act_per),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  shadow_pwm_out #(.CNT_W(CNT_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .pwm_en (ctrl.pwm_en),
    .invert (ctrl.invert),
    .cnt    (cnt),
    .cmp    (act_cmp),
    .pwm_o  (pwm_o)
  );

  // R3
  zero_cmp_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pwm_en && !ctrl.invert && act_cmp == '0) |=> !pwm_o);

  // R3
  over_cmp_high_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pwm_en && !ctrl.invert && act_cmp > act_per && cnt <= act_per) |=> pwm_o);

endmodule

// File: tb/shadow_pwm_test.sv
module shadow_pwm_test;

  localparam int CNT_W  = 8;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam int A_CTRL = 'h00, A_PER = 'h04, A_CMP = 'h08, A_PSH = 'h0C, A_CSH = 'h10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              pwm_o;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  int e0     = 0;
  int k      = 0;
  bit done   = 0;

  shadow_pwm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) edges <= edges + 1;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1200000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  task automatic chk(input logic exp, input string req);
    checks++;
    if (pwm_o !== exp) begin
      errors++;
      $display("FAIL %s: k=%0d pwm_o=%0b expected %0b", req, k, pwm_o, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = DATA_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
    k = edges - e0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    k = edges - e0;
  endtask

  function automatic logic exp_wave(input int kk, input int per, input int cmp,
                                    input int ctl);
    logic hi;
    if (!ctl[1]) return 1'b0;
    hi = (((kk - 1) % (per + 1)) < cmp);
    return hi ^ ctl[2];
  endfunction

  task automatic run_cfg(input int per, input int cmp, input int ctl, input int nper,
                         input string req);
    do_reset();
    wr(A_PER, per);
    wr(A_CMP, cmp);
    wr(A_CTRL, ctl);
    e0 = edges;
    for (int i = 0; i < nper * (per + 1); i++) begin
      step();
      chk(exp_wave(k, per, cmp, ctl), req);
    end
  endtask

  function automatic logic exp_sh(input int kk);
    if (kk <= 6)  return (((kk - 1) % 6) < 2);
    if (kk <= 20) return (((kk - 7) % 4) < 3);
    return (((kk - 7) % 4) < 1);
  endfunction

  initial begin
    do_reset();
    // R1: reset state and enable with cleared registers
    chk(1'b0, "R1");
    e0 = edges;
    wr(A_CTRL, 3);
    for (int i = 0; i < 6; i++) begin
      step();
      chk(1'b0, "R1");
    end

    // R2 R3 R4 R11: sweep of period, compare and polarity
    for (int per = 1; per <= 6; per++)
      for (int cmp = 0; cmp <= per + 2; cmp++) begin
        run_cfg(per, cmp, 3, 3, "R2 R3 R11");
        run_cfg(per, cmp, 7, 2, "R4");
      end

    // R5: running with waveform disabled, either polarity
    run_cfg(3, 2, 1, 3, "R5");
    run_cfg(3, 2, 5, 3, "R5");

    // R9: minimal waveform
    run_cfg(1, 1, 3, 5, "R9");

    // R10: unmapped writes must not reach any register
    do_reset();
    wr(A_PER, 4);
    wr(A_CMP, 2);
    wr('h14, 1);
    wr('h18, 0);
    wr('h24, 0);
    wr('h2C, 0);
    e0 = edges;
    wr(A_CTRL, 3);
    e0 = edges;
    for (int i = 0; i < 15; i++) begin
      step();
      chk(exp_wave(k, 4, 2, 3), "R10");
    end

    // R7 R8 R6 R5: held update in mid-period, direct write, freeze, disable
    do_reset();
    wr(A_PER, 5);
    wr(A_CMP, 2);
    wr(A_CTRL, 3);
    e0 = edges;
    k = 0;
    while (k < 3) begin step(); chk(exp_sh(k), "R7"); end
    wr(A_PSH, 3);
    chk(exp_sh(k), "R7");
    wr(A_CSH, 3);
    chk(exp_sh(k), "R7");
    while (k < 19) begin step(); chk(exp_sh(k), "R7"); end
    wr(A_CMP, 1);
    chk(exp_sh(k), "R8");
    while (k < 33) begin step(); chk(exp_sh(k), "R8"); end
    wr(A_CTRL, 2);                  // counter frozen at 0 from this write
    chk(exp_sh(k), "R6");
    while (k < 44) begin step(); chk(1'b1, "R6"); end
    wr(A_CTRL, 0);
    chk(1'b1, "R5");                // output still reflects the old enable
    while (k < 52) begin step(); chk(1'b0, "R5"); end

    finish_run();
  end

endmodule